// File: doc/BRIEF.md
# PWM Output Action Qualifier

This block drives one PWM output from the state of a time-base counter that sits outside it. On every clock it looks at the counter value, the counting mode and the direction of the current phase. It compares these with the period and with two compare values. It also receives two external trigger strobes and a one-cycle software force request. From these inputs it builds the set of events that are active in this cycle.

Each event has its own 2-bit action code. When several events are active in the same cycle, a fixed priority order picks one of them. That order depends on the mode and on the phase. The action of the winning event is applied to the output flop on the next clock edge.

A compare value set at or above the period is not dropped in every mode. In down and up-down counting, such a compare value takes effect at the period match instead.

Top module: `pwm_act_qual`

## Requirements
- R1: `pwm_out` is low after a synchronous, active-high reset. While `rst` is high, the output stays low whatever events are present.
- R2: The action code is 00 for none, 01 for clear, 10 for set and 11 for toggle. The selected action reaches `pwm_out` on the first rising edge after the inputs that produce it.
- R3: A `frc_pulse` whose `frc_act` is not 00 wins over every hardware event. A force with code 00 lets hardware events decide. A force lasts only for the cycle in which `frc_pulse` is high.
- R4: In up mode (`cnt_mode` 00) the priority from highest to lowest is: force, period match, T1, T2, compare B, compare A, zero. The direction input is ignored, and no down-phase event is ever taken.
- R5: In down mode (`cnt_mode` 01) the priority from highest to lowest is: force, zero match, T1, T2, compare B, compare A, period. The direction input is ignored, and no up-phase event is ever taken.
- R6: In up-down mode (`cnt_mode` 10), the phase is taken as follows. It is incrementing when the counter is 0. It is decrementing when the counter equals the period. At any other value it follows `cnt_dir` (1 means up). While incrementing, the priority from highest to lowest is: force, T1-up, T2-up, compare B up, compare A up, zero.
- R7: In up-down mode while decrementing, the priority from highest to lowest is: force, T1-down, T2-down, compare B down, compare A down, period.
- R8: In up mode, a compare event fires on equality when the compare value is at most the period. When the compare value is greater than the period, the event never fires.
- R9: In down mode, a compare value below the period fires on equality. A compare value at or above the period fires at the period match instead.
- R10: In up-down mode, a compare value below the period fires on equality in the current phase. A compare value at or above the period fires at the period match.
- R11: Active events whose action code is 00 are skipped, and the next lower-priority event with a real action applies. When no event applies, `pwm_out` holds its value.
- R12: In stopped mode (`cnt_mode` 11) no hardware event is taken. Only the software force can change the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_mode | input | 2 | 00 up, 01 down, 10 up-down, 11 stopped |
| cnt_dir | input | 1 | Counter phase in up-down mode, 1 = incrementing |
| cnt_val | input | CW | Time-base counter value |
| prd_val | input | CW | Period value |
| cmpa_val | input | CW | Compare A value |
| cmpb_val | input | CW | Compare B value |
| trig1 | input | 1 | External trigger T1 strobe |
| trig2 | input | 1 | External trigger T2 strobe |
| frc_pulse | input | 1 | Software force request, one cycle |
| frc_act | input | 2 | Action code for the force |
| act_zro | input | 2 | Action on counter equal to zero |
| act_prd | input | 2 | Action on counter equal to period |
| act_cau | input | 2 | Action on compare A, up phase |
| act_cad | input | 2 | Action on compare A, down phase |
| act_cbu | input | 2 | Action on compare B, up phase |
| act_cbd | input | 2 | Action on compare B, down phase |
| act_t1u | input | 2 | Action on T1, up phase |
| act_t1d | input | 2 | Action on T1, down phase |
| act_t2u | input | 2 | Action on T2, up phase |
| act_t2d | input | 2 | Action on T2, down phase |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Event detection and priority arbitration meet whenever two events are active in the same cycle. The bench provokes this by setting both compare values equal to the counter, by raising a trigger on a zero or period match, and by pulsing the force together with a trigger.

Each pair is given actions whose results differ: set against toggle, or clear against set. The output value after the edge therefore shows which event won. Fallback compare events that land on the period match are judged the same way against the period's own action.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TOG  = 2'b11
  } aq_act_e;

  typedef enum logic [1:0] {
    MD_UP   = 2'b00,
    MD_DOWN = 2'b01,
    MD_UPDN = 2'b10,
    MD_STOP = 2'b11
  } aq_mode_e;

  typedef struct packed {
    logic zro;
    logic prd;
    logic cau;
    logic cad;
    logic cbu;
    logic cbd;
    logic t1u;
    logic t1d;
    logic t2u;
    logic t2d;
  } aq_evt_t;

  typedef struct packed {
    aq_act_e zro;
    aq_act_e prd;
    aq_act_e cau;
    aq_act_e cad;
    aq_act_e cbu;
    aq_act_e cbd;
    aq_act_e t1u;
    aq_act_e t1d;
    aq_act_e t2u;
    aq_act_e t2d;
  } aq_cfg_t;

  localparam int NCMP  = 2;  // compare channels: 0 = A, 1 = B
  localparam int NSLOT = 7;  // force plus up to six hardware events

endpackage

// File: rtl/pwm_aq_cmp.sv
module pwm_aq_cmp
  import pwm_aq_pkg::*;
#(
  parameter int CW = 16
) (
  input  aq_mode_e        mode,
  input  logic            phase_up,
  input  logic [CW-1:0]   cnt,
  input  logic [CW-1:0]   prd,
  input  logic [CW-1:0]   cmp,
  output logic            up_ev,
  output logic            dn_ev
);

  logic hit, below, at_prd, fire_fb;

  assign hit     = (cnt == cmp);
  assign below   = (cmp < prd);
  assign at_prd  = (cnt == prd);
  // below the period: equality match; otherwise fall back to period match
  assign fire_fb = below ? hit : at_prd;

  always_comb begin
    up_ev = 1'b0;
    dn_ev = 1'b0;
    case (mode)
      MD_UP:   up_ev = (cmp <= prd) && hit;
      MD_DOWN: dn_ev = fire_fb;
      MD_UPDN: begin
        up_ev = phase_up  && fire_fb;
        dn_ev = !phase_up && fire_fb;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pwm_aq_evt.sv
module pwm_aq_evt
  import pwm_aq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  aq_mode_e        mode,
  input  logic            dir,
  input  logic [CW-1:0]   cnt,
  input  logic [CW-1:0]   prd,
  input  logic [CW-1:0]   cmpa,
  input  logic [CW-1:0]   cmpb,
  input  logic            trig1,
  input  logic            trig2,
  output aq_evt_t         ev,
  output logic            phase_up
);

  logic            hw_on, at_zero, at_prd;
  logic [CW-1:0]   cmp_v [NCMP];
  logic [NCMP-1:0] up_v, dn_v;

  assign hw_on   = (mode != MD_STOP);
  assign at_zero = (cnt == '0);
  assign at_prd  = (cnt == prd);

  // Phase: period match belongs to the falling phase, zero to the rising one
  always_comb begin
    case (mode)
      MD_UP:   phase_up = 1'b1;
      MD_DOWN: phase_up = 1'b0;
      MD_UPDN: phase_up = at_prd ? 1'b0 : (at_zero ? 1'b1 : dir);
      default: phase_up = dir;
    endcase
  end

  assign cmp_v[0] = cmpa;
  assign cmp_v[1] = cmpb;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    pwm_aq_cmp #(.CW(CW)) u_cmp (
      .mode     (mode),
      .phase_up (phase_up),
      .cnt      (cnt),
      .prd      (prd),
      .cmp      (cmp_v[g]),
      .up_ev    (up_v[g]),
      .dn_ev    (dn_v[g])
    );
  end

  always_comb begin
    ev.zro = hw_on && at_zero && (mode != MD_UPDN || phase_up);
    ev.prd = hw_on && at_prd  && (mode != MD_UPDN || !phase_up);
    ev.cau = hw_on && up_v[0];
    ev.cad = hw_on && dn_v[0];
    ev.cbu = hw_on && up_v[1];
    ev.cbd = hw_on && dn_v[1];
    ev.t1u = hw_on && trig1 && phase_up;
    ev.t1d = hw_on && trig1 && !phase_up;
    ev.t2u = hw_on && trig2 && phase_up;
    ev.t2d = hw_on && trig2 && !phase_up;
  end

  // R4: up counting never raises a falling-phase event
  a_r4_no_down_in_up: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_UP) |-> !(ev.cad || ev.cbd || ev.t1d || ev.t2d));
  // R5: down counting never raises a rising-phase event
  a_r5_no_up_in_down: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_DOWN) |-> !(ev.cau || ev.cbu || ev.t1u || ev.t2u));
  // R12: stopped counter produces no hardware events
  a_r12_stop_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_STOP) |-> (ev == '0));
  // R8: compare above period never fires in up mode
  a_r8_over_never: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_UP && cmpa > prd) |-> !ev.cau);
  // R10: in up-down, at most one compare-A event per cycle
  a_r10_one_phase: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_UPDN) |-> $countones({ev.cau, ev.cad}) <= 1);

endmodule

// File: rtl/pwm_aq_arb.sv
module pwm_aq_arb
  import pwm_aq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  aq_mode_e  mode,
  input  logic      phase_up,
  input  aq_evt_t   ev,
  input  aq_cfg_t   cfg,
  input  logic      frc,
  input  aq_act_e   frc_act,
  output aq_act_e   sel
);

  logic [NSLOT-1:0] s_ev;
  aq_act_e          s_act [NSLOT];

  // Slot 0 is highest priority; the order depends on mode and phase
  always_comb begin
    s_ev = '0;
    for (int i = 0; i < NSLOT; i++) s_act[i] = ACT_NONE;
    s_ev[0] = frc;  s_act[0] = frc_act;
    case (mode)
      MD_UP: begin
        s_ev[1] = ev.prd; s_act[1] = cfg.prd;
        s_ev[2] = ev.t1u; s_act[2] = cfg.t1u;
        s_ev[3] = ev.t2u; s_act[3] = cfg.t2u;
        s_ev[4] = ev.cbu; s_act[4] = cfg.cbu;
        s_ev[5] = ev.cau; s_act[5] = cfg.cau;
        s_ev[6] = ev.zro; s_act[6] = cfg.zro;
      end
      MD_DOWN: begin
        s_ev[1] = ev.zro; s_act[1] = cfg.zro;
        s_ev[2] = ev.t1d; s_act[2] = cfg.t1d;
        s_ev[3] = ev.t2d; s_act[3] = cfg.t2d;
        s_ev[4] = ev.cbd; s_act[4] = cfg.cbd;
        s_ev[5] = ev.cad; s_act[5] = cfg.cad;
        s_ev[6] = ev.prd; s_act[6] = cfg.prd;
      end
      MD_UPDN: begin
        if (phase_up) begin
          s_ev[1] = ev.t1u; s_act[1] = cfg.t1u;
          s_ev[2] = ev.t2u; s_act[2] = cfg.t2u;
          s_ev[3] = ev.cbu; s_act[3] = cfg.cbu;
          s_ev[4] = ev.cau; s_act[4] = cfg.cau;
          s_ev[5] = ev.zro; s_act[5] = cfg.zro;
        end else begin
          s_ev[1] = ev.t1d; s_act[1] = cfg.t1d;
          s_ev[2] = ev.t2d; s_act[2] = cfg.t2d;
          s_ev[3] = ev.cbd; s_act[3] = cfg.cbd;
          s_ev[4] = ev.cad; s_act[4] = cfg.cad;
          s_ev[5] = ev.prd; s_act[5] = cfg.prd;
        end
      end
      default: ;
    endcase
  end

  // Scan lowest to highest; a higher slot with a real action overwrites
  always_comb begin
    sel = ACT_NONE;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (s_ev[i] && s_act[i] != ACT_NONE) sel = s_act[i];
    end
  end

  // R3: an effective force always decides the action
  a_r3_force_wins: assert property (@(posedge clk) disable iff (rst)
    (frc && frc_act != ACT_NONE) |-> (sel == frc_act));
  // R11: with nothing active, no action is selected
  a_r11_idle_none: assert property (@(posedge clk) disable iff (rst)
    (!frc && ev == '0) |-> (sel == ACT_NONE));

endmodule

// File: rtl/pwm_aq_out.sv
module pwm_aq_out
  import pwm_aq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  aq_act_e  act,
  output logic     q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      case (act)
        ACT_CLR: q <= 1'b0;
        ACT_SET: q <= 1'b1;
        ACT_TOG: q <= ~q;
        default: q <= q;
      endcase
    end
  end

  // R2: each code has its effect one edge later
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_CLR) |=> !q);
  a_r2_set: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_SET) |=> q);
  a_r2_toggle: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_TOG) |=> (q != $past(q)));
  // R11: no action holds the output
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_NONE) |=> $stable(q));

endmodule

// File: rtl/pwm_act_qual.sv
module pwm_act_qual
  import pwm_aq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cnt_mode,
  input  logic          cnt_dir,
  input  logic [CW-1:0] cnt_val,
  input  logic [CW-1:0] prd_val,
  input  logic [CW-1:0] cmpa_val,
  input  logic [CW-1:0] cmpb_val,
  input  logic          trig1,
  input  logic          trig2,
  input  logic          frc_pulse,
  input  logic [1:0]    frc_act,
  input  logic [1:0]    act_zro,
  input  logic [1:0]    act_prd,
  input  logic [1:0]    act_cau,
  input  logic [1:0]    act_cad,
  input  logic [1:0]    act_cbu,
  input  logic [1:0]    act_cbd,
  input  logic [1:0]    act_t1u,
  input  logic [1:0]    act_t1d,
  input  logic [1:0]    act_t2u,
  input  logic [1:0]    act_t2d,
  output logic          pwm_out
);

  aq_mode_e mode;
  aq_cfg_t  cfg;
  aq_evt_t  ev;
  aq_act_e  sel;
  logic     phase_up;

  assign mode    = aq_mode_e'(cnt_mode);
  assign cfg.zro = aq_act_e'(act_zro);
  assign cfg.prd = aq_act_e'(act_prd);
  assign cfg.cau = aq_act_e'(act_cau);
  assign cfg.cad = aq_act_e'(act_cad);
  assign cfg.cbu = aq_act_e'(act_cbu);
  assign cfg.cbd = aq_act_e'(act_cbd);
  assign cfg.t1u = aq_act_e'(act_t1u);
  assign cfg.t1d = aq_act_e'(act_t1d);
  assign cfg.t2u = aq_act_e'(act_t2u);
  assign cfg.t2d = aq_act_e'(act_t2d);

  pwm_aq_evt #(.CW(CW)) u_evt (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .dir      (cnt_dir),
    .cnt      (cnt_val),
    .prd      (prd_val),
    .cmpa     (cmpa_val),
    .cmpb     (cmpb_val),
    .trig1    (trig1),
    .trig2    (trig2),
    .ev       (ev),
    .phase_up (phase_up)
  );

  pwm_aq_arb u_arb (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .phase_up (phase_up),
    .ev       (ev),
    .cfg      (cfg),
    .frc      (frc_pulse),
    .frc_act  (aq_act_e'(frc_act)),
    .sel      (sel)
  );

  pwm_aq_out u_out (
    .clk (clk),
    .rst (rst),
    .act (sel),
    .q   (pwm_out)
  );

  // R1: output is low on the cycle after reset was applied
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> !pwm_out);

endmodule

// File: tb/pwm_act_qual_bench.sv
module pwm_act_qual_bench;

  localparam int CW = 16;
  localparam logic [1:0] U = 2'd0, D = 2'd1, B = 2'd2, S = 2'd3;
  localparam logic [1:0] AN = 2'd0, AC = 2'd1, AS = 2'd2, AT = 2'd3;

  typedef struct packed {
    logic [1:0]    md;
    logic          dir;
    logic [CW-1:0] cnt;
    logic [CW-1:0] prd;
    logic [CW-1:0] ca;
    logic [CW-1:0] cb;
    logic          t1;
    logic          t2;
    logic          f;
    logic [1:0]    fa;
    logic          ex;
  } vec_t;

  // Actions for the table: zro S, prd C, cau C, cad S, cbu T, cbd T,
  // t1u S, t1d C, t2u C, t2d S
  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{U,1,  0,100, 40, 60,0,0,0,AN,1},  // R4 zero set
    '{U,1, 40,100, 40, 60,0,0,0,AN,0},  // R8 compare A clear
    '{U,1, 60,100, 40, 60,0,0,0,AN,1},  // R8 compare B toggle
    '{U,1,100,100, 40, 60,0,0,0,AN,0},  // R4 period clear
    '{U,1, 60,100, 60, 60,0,0,0,AN,1},  // R4 B over A
    '{U,1, 60,100, 40, 60,1,0,0,AN,1},  // R4 T1 over B
    '{U,1,  0,100, 40, 60,0,1,0,AN,0},  // R4 T2 over zero
    '{U,1,  0,100, 40, 60,0,0,0,AN,1},
    '{U,1,100,100,100,100,1,0,0,AN,0},  // R4 period over T1/B/A; R8 cmp==prd
    '{U,1,  0,100, 40, 60,0,0,0,AN,1},
    '{U,1,120,100,120,120,0,0,0,AN,1},  // R8 compare above period never
    '{D,0, 60,100, 40, 60,0,0,0,AN,0},  // R9 compare B down
    '{D,0, 40,100, 40, 60,0,0,0,AN,1},  // R9 compare A down
    '{D,0, 50,100, 40, 60,1,0,0,AN,0},  // R5 T1 down
    '{D,0,  0,100, 40, 60,1,0,0,AN,1},  // R5 zero over T1
    '{D,0,100,100, 40, 60,0,0,0,AN,0},  // R5 period
    '{D,0,100,100,150, 40,0,0,0,AN,1},  // R9 A fallback over period
    '{D,0,100,100,150,100,0,0,0,AN,0},  // R9 B fallback over A
    '{D,1,100,100, 40, 60,0,1,0,AN,1},  // R5 T2 over period, dir ignored
    '{U,0, 40,100, 40, 60,0,0,0,AN,0},  // R4 dir ignored in up mode
    '{B,0, 40,100, 40, 60,0,0,0,AN,1},  // R7 compare A down
    '{B,1, 40,100, 40, 60,0,0,0,AN,0},  // R6 compare A up
    '{B,1,  0,100, 40, 60,0,0,0,AN,1},  // R6 zero
    '{B,1,100,100, 40, 40,0,0,0,AN,0},  // R6 period is falling phase
    '{B,0,100,100,200, 40,0,0,0,AN,1},  // R10 A fallback over period
    '{B,1,  0,100, 40, 60,0,1,0,AN,0},  // R6 T2 over zero
    '{B,0,  0,100, 40, 60,0,0,0,AN,1},  // R6 zero is rising phase
    '{B,0, 30,100, 40, 60,1,1,0,AN,0},  // R7 T1 over T2
    '{B,1, 30,100, 40, 60,1,1,0,AN,1},  // R6 T1 over T2
    '{B,1, 30,100, 40, 60,1,0,1,AC,0},  // R3 force over T1
    '{B,1, 30,100, 40, 60,1,0,1,AN,1},  // R3 force none defers
    '{S,1,  0,100, 40, 60,1,0,0,AN,1},  // R12 stopped ignores events
    '{S,1,  0,100, 40, 60,0,0,1,AT,0},  // R12 force works when stopped
    '{B,0, 60,100, 60, 60,0,0,0,AN,1},  // R7 B over A down
    '{B,1, 60,100, 60, 60,0,0,0,AN,0},  // R6 B over A up
    '{B,1,100,100,100, 40,0,0,0,AN,1}   // R10 cmp equal to period falls back
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cnt_mode;
  logic          cnt_dir;
  logic [CW-1:0] cnt_val, prd_val, cmpa_val, cmpb_val;
  logic          trig1, trig2, frc_pulse;
  logic [1:0]    frc_act;
  logic [1:0]    act_zro, act_prd, act_cau, act_cad, act_cbu, act_cbd;
  logic [1:0]    act_t1u, act_t1d, act_t2u, act_t2d;
  logic          pwm_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pwm_act_qual #(.CW(CW)) u_pwm_act_qual (
    .clk(clk), .rst(rst), .cnt_mode(cnt_mode), .cnt_dir(cnt_dir),
    .cnt_val(cnt_val), .prd_val(prd_val), .cmpa_val(cmpa_val),
    .cmpb_val(cmpb_val), .trig1(trig1), .trig2(trig2),
    .frc_pulse(frc_pulse), .frc_act(frc_act),
    .act_zro(act_zro), .act_prd(act_prd), .act_cau(act_cau),
    .act_cad(act_cad), .act_cbu(act_cbu), .act_cbd(act_cbd),
    .act_t1u(act_t1u), .act_t1d(act_t1d), .act_t2u(act_t2u),
    .act_t2d(act_t2d), .pwm_out(pwm_out)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic default_cfg();
    act_zro = AS; act_prd = AC; act_cau = AC; act_cad = AS;
    act_cbu = AT; act_cbd = AT; act_t1u = AS; act_t1d = AC;
    act_t2u = AC; act_t2d = AS;
  endtask

  task automatic drive(input vec_t v);
    cnt_mode = v.md;  cnt_dir = v.dir; cnt_val = v.cnt; prd_val = v.prd;
    cmpa_val = v.ca;  cmpb_val = v.cb; trig1 = v.t1;    trig2 = v.t2;
    frc_pulse = v.f;  frc_act = v.fa;
  endtask

  // idle: up mode, counter between compares, no strobes
  localparam vec_t IDLE = '{U,1,50,100,40,60,0,0,0,AN,0};

  initial begin
    default_cfg();
    // R1: reset held with a set event present keeps the output low
    drive('{U,1,0,100,40,60,0,0,0,AN,0});
    repeat (3) @(negedge clk);
    check(pwm_out, 1'b0, "R1 reset holds low");
    drive(IDLE);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pwm_out, 1'b0, "R1 low after reset");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check(pwm_out, VEC[i].ex, $sformatf("R2 vector %0d", i));
    end
    // output is 1 here

    // R11: T1 with no action is skipped, zero (clear) applies
    act_zro = AC; act_t1u = AN;
    drive('{U,1,0,100,40,60,1,0,0,AN,0});
    @(negedge clk);
    check(pwm_out, 1'b0, "R11 no-action skip");
    default_cfg();

    // R11: no event holds the value
    drive(IDLE);
    @(negedge clk);
    check(pwm_out, 1'b0, "R11 hold without event");

    // R2: toggle on consecutive zero matches
    act_zro = AT;
    drive('{U,1,0,100,40,60,0,0,0,AN,0});
    @(negedge clk);
    check(pwm_out, 1'b1, "R2 toggle first");
    @(negedge clk);
    check(pwm_out, 1'b0, "R2 toggle second");
    default_cfg();

    // R3: force acts for one cycle only
    drive('{U,1,50,100,40,60,0,0,1,AS,0});
    @(negedge clk);
    check(pwm_out, 1'b1, "R3 force set");
    drive('{U,1,50,100,40,60,0,0,0,AC,0});
    @(negedge clk);
    check(pwm_out, 1'b1, "R3 force gone after pulse");

    // R1: reset mid-run clears a high output
    rst = 1'b1;
    @(negedge clk);
    check(pwm_out, 1'b0, "R1 reset clears");
    rst = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule